// File: doc/BRIEF.md
# Platform Interrupt Claim Controller

This block tracks interrupt requests from a set of sources and presents them to processor contexts through a claim/complete handshake. Each source has a programmable priority. Each context has its own enable mask, priority threshold and claim/complete register. Sources signal a request with a single-cycle post pulse, and that pulse latches a pending bit. For every context the block forms an effective priority vector and drives it out to a separate selector. The selector sends back the winning source ID and its priority. The block compares that winner against the context threshold and drives the context's interrupt line.

Software reaches all state through a 32-bit register bus with a valid/ready handshake. A read of a context's claim register takes the winning source: the read returns its ID, clears its pending bit and masks the context's line until the context writes the claim register again (the complete). Contexts come in pairs per hart. The even context of a pair drives the hart's machine-level line and the odd context drives its supervisor-level line.

Top module: `plic_gate`

## Requirements
- R1: A post pulse on source n sets its pending bit. The pending bits read back packed, with source n at bit n&31 of the word at PEND_BASE + 4*(n>>5). Source 0 is reserved and never becomes pending.
- R2: Each source has a PRIO_W-bit priority register at PRIO_BASE + 4*n. A write keeps the low PRIO_W bits, and a read returns the value zero-extended.
- R3: For context c and source n, the effective priority output equals the source priority when the source is both pending and enabled in c, and zero otherwise. A priority or enable write changes it from the next cycle on.
- R4: A context's line is high only when three conditions hold: the winning priority is strictly above the context threshold, the winning ID is nonzero, and the context has no outstanding claim. The line follows these inputs with one register stage.
- R5: A claim read with no outstanding claim returns the winning ID if that source is pending. The same read records the ID as outstanding and clears its pending bit. If the winning source is not pending, the read returns 0 and changes no state.
- R6: A claim read while a claim is outstanding returns the outstanding ID again and changes no state.
- R7: Any write to a context's claim register ends the outstanding claim, whatever data is written.
- R8: Context c drives hart c>>1. The line is the machine-level line for even c and the supervisor-level line for odd c.
- R9: The pending words are read-only. Addresses outside the priority, pending, enable, threshold and claim registers read 0 and ignore writes. Enables sit at EN_BASE + c*EN_STRIDE. Thresholds sit at CTX_BASE + c*CTX_STRIDE, and each context's claim register sits 4 bytes above its threshold.
- R10: Reset clears all priorities, pending bits, enables, thresholds and outstanding claims, and holds every interrupt line low.
- R11: The bus ready output is always high. Read data is valid for exactly one cycle, in the cycle after the read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| post_i | input | NUM_SRC | Single-cycle request pulse per source |
| bus_valid_i | input | 1 | Register access request |
| bus_ready_o | output | 1 | Access accepted (always high) |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 32 | Read data |
| eff_prio_o | output | NUM_CTX*NUM_SRC*PRIO_W | Effective priority per context and source, to the selector |
| win_id_i | input | NUM_CTX*ID_W | Winning source ID per context, from the selector |
| win_prio_i | input | NUM_CTX*PRIO_W | Winning priority per context, from the selector |
| irq_m_o | output | NUM_CTX/2 | Machine-level line per hart |
| irq_s_o | output | NUM_CTX/2 | Supervisor-level line per hart |

## Verification
The assertions assume that the selector inputs are a function of the effective priority outputs. They also assume that each bus request lasts one cycle and that post pulses last one cycle. The bench meets these conditions with a combinational maximum-finder that favours the lowest ID on a tie, and by driving every access and pulse for exactly one cycle between falling edges. The properties then tie claim ownership to claim reads and to the interrupt lines, and tie the effective priorities to the pending bits.

// File: rtl/plic_gate_pkg.sv
package plic_gate_pkg;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_PRIO,
    RG_PEND,
    RG_EN,
    RG_THR,
    RG_CLAIM
  } region_e;

  typedef struct packed {
    region_e     region;
    int unsigned src;
    int unsigned ctx;
    int unsigned word;
  } decode_t;

endpackage

// File: rtl/plic_gate_srcbank.sv
module plic_gate_srcbank #(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 3,
  localparam int ID_W   = $clog2(NUM_SRC)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SRC-1:0]              post_i,
  input  logic [NUM_SRC-1:0]              clr_i,
  input  logic                            prio_we_i,
  input  logic [ID_W-1:0]                 prio_idx_i,
  input  logic [PRIO_W-1:0]               prio_wdata_i,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_o,
  output logic [NUM_SRC-1:0]              pend_o
);

  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q, prio_d;
  logic [NUM_SRC-1:0]             pend_q, pend_d;

  always_comb begin
    prio_d = prio_q;
    if (prio_we_i) prio_d[prio_idx_i] = prio_wdata_i;
    // a post in the same cycle as a claim clear wins
    pend_d    = (pend_q & ~clr_i) | post_i;
    pend_d[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
      pend_q <= '0;
    end else begin
      if (prio_we_i) prio_q <= prio_d;
      pend_q <= pend_d;
    end
  end

  assign prio_o = prio_q;
  assign pend_o = pend_q;

endmodule

// File: rtl/plic_gate_ctx.sv
module plic_gate_ctx #(
  parameter int NUM_SRC  = 8,
  parameter int PRIO_W   = 3,
  localparam int ID_W    = $clog2(NUM_SRC),
  localparam int NUM_WORD = (NUM_SRC + 31) / 32,
  localparam int WORD_W  = (NUM_WORD > 1) ? $clog2(NUM_WORD) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            en_we_i,
  input  logic [WORD_W-1:0]               en_word_i,
  input  logic                            thr_we_i,
  input  logic [31:0]                     wdata_i,
  input  logic                            claim_rd_i,
  input  logic                            cmpl_wr_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_i,
  input  logic [NUM_SRC-1:0]              pend_i,
  input  logic [ID_W-1:0]                 win_id_i,
  input  logic [PRIO_W-1:0]               win_prio_i,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]  eff_o,
  output logic [NUM_SRC-1:0]              en_o,
  output logic [PRIO_W-1:0]               thr_o,
  output logic                            busy_o,
  output logic                            grant_o,
  output logic [ID_W-1:0]                 claim_id_o,
  output logic                            irq_o
);

  logic [NUM_SRC-1:0] en_q, en_d;
  logic [PRIO_W-1:0]  thr_q;
  logic               busy_q, busy_d;
  logic [ID_W-1:0]    busy_id_q, busy_id_d;
  logic               irq_q, irq_d;
  logic               win_pending;

  assign win_pending = pend_i[win_id_i];
  assign grant_o     = claim_rd_i && !busy_q && win_pending;

  always_comb begin
    en_d = en_q;
    for (int b = 0; b < 32; b++) begin
      if (en_we_i && (int'(en_word_i) * 32 + b < NUM_SRC))
        en_d[int'(en_word_i) * 32 + b] = wdata_i[b];
    end
    busy_d    = busy_q;
    busy_id_d = busy_id_q;
    if (grant_o) begin
      busy_d    = 1'b1;
      busy_id_d = win_id_i;
    end else if (cmpl_wr_i) begin
      busy_d = 1'b0;
    end
    irq_d = (win_prio_i > thr_q) && (win_id_i != '0) && !busy_d;
  end

  always_comb begin
    for (int s = 0; s < NUM_SRC; s++)
      eff_o[s] = (pend_i[s] && en_q[s]) ? prio_i[s] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      thr_q     <= '0;
      busy_q    <= 1'b0;
      busy_id_q <= '0;
      irq_q     <= 1'b0;
    end else begin
      if (en_we_i)  en_q  <= en_d;
      if (thr_we_i) thr_q <= wdata_i[PRIO_W-1:0];
      busy_q    <= busy_d;
      busy_id_q <= busy_id_d;
      irq_q     <= irq_d;
    end
  end

  assign en_o       = en_q;
  assign thr_o      = thr_q;
  assign busy_o     = busy_q;
  assign claim_id_o = busy_q ? busy_id_q : (win_pending ? win_id_i : '0);
  assign irq_o      = irq_q;

endmodule

// File: rtl/plic_gate.sv
module plic_gate
  import plic_gate_pkg::*;
#(
  parameter int          NUM_SRC    = 8,
  parameter int          NUM_CTX    = 2,
  parameter int          PRIO_W     = 3,
  parameter int          ADDR_W     = 22,
  parameter int unsigned PRIO_BASE  = 32'h0000_0000,
  parameter int unsigned PEND_BASE  = 32'h0000_1000,
  parameter int unsigned EN_BASE    = 32'h0000_2000,
  parameter int unsigned EN_STRIDE  = 32'h0000_0080,
  parameter int unsigned CTX_BASE   = 32'h0020_0000,
  parameter int unsigned CTX_STRIDE = 32'h0000_1000,
  localparam int ID_W     = $clog2(NUM_SRC),
  localparam int NUM_WORD = (NUM_SRC + 31) / 32,
  localparam int WORD_W   = (NUM_WORD > 1) ? $clog2(NUM_WORD) : 1,
  localparam int NUM_HART = NUM_CTX / 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_SRC-1:0]               post_i,
  input  logic                             bus_valid_i,
  output logic                             bus_ready_o,
  input  logic                             bus_we_i,
  input  logic [ADDR_W-1:0]                bus_addr_i,
  input  logic [31:0]                      bus_wdata_i,
  output logic                             rd_valid_o,
  output logic [31:0]                      rd_data_o,
  output logic [NUM_CTX*NUM_SRC*PRIO_W-1:0] eff_prio_o,
  input  logic [NUM_CTX*ID_W-1:0]          win_id_i,
  input  logic [NUM_CTX*PRIO_W-1:0]        win_prio_i,
  output logic [NUM_HART-1:0]              irq_m_o,
  output logic [NUM_HART-1:0]              irq_s_o
);

  decode_t dec;
  logic                            wr_acc, rd_acc;
  logic [NUM_SRC-1:0]              src_pend, src_clr;
  logic [NUM_SRC-1:0][PRIO_W-1:0]  src_prio;
  logic [NUM_CTX-1:0]              ctx_en_we, ctx_thr_we, ctx_claim_rd, ctx_cmpl_wr;
  logic [NUM_CTX-1:0]              ctx_busy, ctx_grant, ctx_irq;
  logic [ID_W-1:0]                 ctx_win_id   [NUM_CTX];
  logic [ID_W-1:0]                 ctx_claim_id [NUM_CTX];
  logic [PRIO_W-1:0]               ctx_thr      [NUM_CTX];
  logic [NUM_SRC-1:0]              ctx_en       [NUM_CTX];
  logic [31:0]                     rd_d, rd_q;
  logic                            rd_valid_q;

  assign wr_acc      = bus_valid_i && bus_we_i;
  assign rd_acc      = bus_valid_i && !bus_we_i;
  assign bus_ready_o = 1'b1;

  // address decode
  always_comb begin
    int unsigned a;
    a   = 32'(bus_addr_i);
    dec = '{region: RG_NONE, src: 0, ctx: 0, word: 0};
    if (a[1:0] == 2'b00) begin
      if (a >= PRIO_BASE && a < PRIO_BASE + 4 * NUM_SRC) begin
        dec.region = RG_PRIO;
        dec.src    = (a - PRIO_BASE) >> 2;
      end
      if (a >= PEND_BASE && a < PEND_BASE + 4 * NUM_WORD) begin
        dec.region = RG_PEND;
        dec.word   = (a - PEND_BASE) >> 2;
      end
      for (int c = 0; c < NUM_CTX; c++) begin
        if (a >= EN_BASE + c * EN_STRIDE && a < EN_BASE + c * EN_STRIDE + 4 * NUM_WORD) begin
          dec.region = RG_EN;
          dec.ctx    = c;
          dec.word   = (a - EN_BASE - c * EN_STRIDE) >> 2;
        end
        if (a == CTX_BASE + c * CTX_STRIDE) begin
          dec.region = RG_THR;
          dec.ctx    = c;
        end
        if (a == CTX_BASE + c * CTX_STRIDE + 4) begin
          dec.region = RG_CLAIM;
          dec.ctx    = c;
        end
      end
    end
  end

  // per-context strobes and claim-driven pending clears
  always_comb begin
    src_clr = '0;
    for (int c = 0; c < NUM_CTX; c++) begin
      ctx_en_we[c]    = wr_acc && dec.region == RG_EN    && dec.ctx == c;
      ctx_thr_we[c]   = wr_acc && dec.region == RG_THR   && dec.ctx == c;
      ctx_cmpl_wr[c]  = wr_acc && dec.region == RG_CLAIM && dec.ctx == c;
      ctx_claim_rd[c] = rd_acc && dec.region == RG_CLAIM && dec.ctx == c;
      if (ctx_grant[c]) src_clr[ctx_win_id[c]] = 1'b1;
    end
  end

  plic_gate_srcbank #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_srcbank (
    .clk          (clk),
    .rst_n        (rst_n),
    .post_i       (post_i),
    .clr_i        (src_clr),
    .prio_we_i    (wr_acc && dec.region == RG_PRIO),
    .prio_idx_i   (ID_W'(dec.src)),
    .prio_wdata_i (bus_wdata_i[PRIO_W-1:0]),
    .prio_o       (src_prio),
    .pend_o       (src_pend)
  );

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    logic [NUM_SRC-1:0][PRIO_W-1:0] eff;
    assign ctx_win_id[c] = win_id_i[c*ID_W +: ID_W];
    plic_gate_ctx #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_ctx (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_we_i    (ctx_en_we[c]),
      .en_word_i  (WORD_W'(dec.word)),
      .thr_we_i   (ctx_thr_we[c]),
      .wdata_i    (bus_wdata_i),
      .claim_rd_i (ctx_claim_rd[c]),
      .cmpl_wr_i  (ctx_cmpl_wr[c]),
      .prio_i     (src_prio),
      .pend_i     (src_pend),
      .win_id_i   (ctx_win_id[c]),
      .win_prio_i (win_prio_i[c*PRIO_W +: PRIO_W]),
      .eff_o      (eff),
      .en_o       (ctx_en[c]),
      .thr_o      (ctx_thr[c]),
      .busy_o     (ctx_busy[c]),
      .grant_o    (ctx_grant[c]),
      .claim_id_o (ctx_claim_id[c]),
      .irq_o      (ctx_irq[c])
    );
    assign eff_prio_o[c*NUM_SRC*PRIO_W +: NUM_SRC*PRIO_W] = eff;
  end

  for (genvar h = 0; h < NUM_HART; h++) begin : g_hart
    assign irq_m_o[h] = ctx_irq[2*h];
    assign irq_s_o[h] = ctx_irq[2*h+1];
  end

  // read data mux
  always_comb begin
    rd_d = '0;
    unique case (dec.region)
      RG_PRIO:  rd_d = 32'(src_prio[dec.src]);
      RG_PEND:
        for (int b = 0; b < 32; b++)
          if (dec.word * 32 + b < NUM_SRC) rd_d[b] = src_pend[dec.word * 32 + b];
      RG_EN:
        for (int b = 0; b < 32; b++)
          if (dec.word * 32 + b < NUM_SRC) rd_d[b] = ctx_en[dec.ctx][dec.word * 32 + b];
      RG_THR:   rd_d = 32'(ctx_thr[dec.ctx]);
      RG_CLAIM: rd_d = 32'(ctx_claim_id[dec.ctx]);
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_q       <= '0;
    end else begin
      rd_valid_q <= rd_acc;
      if (rd_acc) rd_q <= rd_d;
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_q;

endmodule

// File: rtl/plic_gate_chk.sv
module plic_gate_chk #(
  parameter int          NUM_SRC    = 8,
  parameter int          NUM_CTX    = 2,
  parameter int          PRIO_W     = 3,
  parameter int          ADDR_W     = 22,
  parameter int unsigned CTX_BASE   = 32'h0020_0000,
  parameter int unsigned CTX_STRIDE = 32'h0000_1000,
  localparam int ID_W = $clog2(NUM_SRC)
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              bus_valid_i,
  input logic                              bus_we_i,
  input logic [ADDR_W-1:0]                 bus_addr_i,
  input logic                              rd_valid_o,
  input logic [NUM_CTX*ID_W-1:0]           win_id_i,
  input logic [NUM_CTX-1:0]                ctx_busy,
  input logic [NUM_CTX-1:0]                ctx_irq,
  input logic [NUM_SRC-1:0]                src_pend,
  input logic [NUM_CTX*NUM_SRC*PRIO_W-1:0] eff_prio_o
);

  // R10: quiet outputs while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R10: assert (ctx_irq == '0 && !rd_valid_o);
    end
  end

  // R11: read data follows an accepted read by one cycle
  assert_rd_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_i && !bus_we_i) |=> rd_valid_o);

  // R1: reserved source never pending
  assert_src0_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !src_pend[0]);

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_c
    // R4: no line while a claim is outstanding
    assert_mask_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ctx_busy[c] |-> !ctx_irq[c]);
    // R4: a raised line follows a nonzero winner
    assert_nonzero_win_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ctx_irq[c] |-> $past(win_id_i[c*ID_W +: ID_W] != '0));
    // R5: ownership starts only from a claim read of this context
    assert_claim_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctx_busy[c]) |-> $past(bus_valid_i && !bus_we_i &&
        32'(bus_addr_i) == CTX_BASE + c * CTX_STRIDE + 4));
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_s
      // R3: effective priority is zero without a pending bit
      assert_eff_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !src_pend[s] |-> eff_prio_o[(c*NUM_SRC+s)*PRIO_W +: PRIO_W] == '0);
    end
  end

endmodule

bind plic_gate plic_gate_chk #(
  .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W),
  .CTX_BASE(CTX_BASE), .CTX_STRIDE(CTX_STRIDE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid_i(bus_valid_i), .bus_we_i(bus_we_i),
  .bus_addr_i(bus_addr_i), .rd_valid_o(rd_valid_o), .win_id_i(win_id_i),
  .ctx_busy(ctx_busy), .ctx_irq(ctx_irq), .src_pend(src_pend),
  .eff_prio_o(eff_prio_o)
);

// File: tb/plic_gate_tb.sv
module plic_gate_tb;
  localparam int NS = 8, NC = 2, PW = 3, AW = 22, IW = 3;
  localparam logic [AW-1:0] A_PEND = 22'h1000, A_EN0 = 22'h2000, A_EN1 = 22'h2080,
    A_THR0 = 22'h200000, A_CLM0 = 22'h200004, A_THR1 = 22'h201000, A_CLM1 = 22'h201004;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NS-1:0] post = '0;
  logic bus_valid = 1'b0, bus_we = 1'b0, bus_ready, rd_valid;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, rd_data;
  logic [NC*NS*PW-1:0] eff;
  logic [NC*IW-1:0] win_id;
  logic [NC*PW-1:0] win_prio;
  logic [0:0] irq_m, irq_s;

  int vectors = 0, misses = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  plic_gate u_dut (
    .clk(clk), .rst_n(rst_n), .post_i(post), .bus_valid_i(bus_valid),
    .bus_ready_o(bus_ready), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .eff_prio_o(eff), .win_id_i(win_id), .win_prio_i(win_prio),
    .irq_m_o(irq_m), .irq_s_o(irq_s)
  );

  // external selector model: highest effective priority, lowest ID on ties
  always_comb begin
    for (int c = 0; c < NC; c++) begin
      logic [IW-1:0] bi;
      logic [PW-1:0] bp;
      bi = '0; bp = '0;
      for (int s = 0; s < NS; s++)
        if (eff[(c*NS+s)*PW +: PW] > bp) begin
          bp = eff[(c*NS+s)*PW +: PW];
          bi = IW'(s);
        end
      win_id[c*IW +: IW]   = bi;
      win_prio[c*PW +: PW] = bp;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) chk(rd_data, 32'hdead_beef, "R11 unexpected read data");
      else chk(rd_data, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic pulse(input int n);
    @(negedge clk);
    post = '0; post[n] = 1'b1;
    @(negedge clk);
    post = '0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #200_000;
    misses++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(32'(irq_m), 0, "R10 machine line in reset");
    chk(32'(rd_valid), 0, "R10 no read data in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(32'(bus_ready), 1, "R11 ready high");
    rd(A_PEND, 32'h0, "R10 pending cleared");
    rd(22'h00C, 32'h0, "R10 priority cleared");
    rd(A_EN0, 32'h0, "R10 enable cleared");

    wr(22'h00C, 5); wr(22'h014, 2); wr(22'h018, 5); wr(22'h004, 32'hFF);
    rd(22'h00C, 5, "R2 priority readback");
    rd(22'h004, 7, "R2 priority width mask");

    pulse(3); pulse(5); pulse(0);
    rd(A_PEND, 32'h28, "R1 pending packing, source 0 reserved");
    chk(32'(eff[3*PW +: PW]), 0, "R3 not enabled gives zero");
    settle();
    chk(32'(irq_m), 0, "R4 no enable no line");

    wr(A_EN0, 32'h28);
    settle();
    chk(32'(eff[3*PW +: PW]), 5, "R3 pending and enabled");
    chk(32'(irq_m), 1, "R4 above threshold");
    chk(32'(irq_s), 0, "R8 odd context quiet");

    wr(A_THR0, 5); settle();
    chk(32'(irq_m), 0, "R4 equal to threshold");
    wr(A_THR0, 4); settle();
    chk(32'(irq_m), 1, "R4 one above threshold");

    rd(A_CLM0, 3, "R5 claim returns winner");
    @(negedge clk);
    chk(32'(irq_m), 0, "R4 masked after claim");
    rd(A_PEND, 32'h20, "R5 claim clears pending");
    wr(A_THR0, 0); settle();
    chk(32'(irq_m), 0, "R4 masked while outstanding");
    rd(A_CLM0, 3, "R6 repeated claim");
    rd(A_PEND, 32'h20, "R6 repeated claim keeps pending");

    wr(A_CLM0, 9); settle();
    chk(32'(irq_m), 1, "R7 mismatched complete accepted");
    rd(A_CLM0, 5, "R5 next winner");
    wr(A_CLM0, 5); settle();
    chk(32'(irq_m), 0, "R4 nothing pending");
    rd(A_CLM0, 0, "R5 empty claim");
    rd(A_CLM0, 0, "R5 empty claim records nothing");

    pulse(3); settle();
    chk(32'(irq_m), 1, "R4 new post");
    wr(22'h00C, 0); settle();
    chk(32'(eff[3*PW +: PW]), 0, "R3 priority write recomputes");
    chk(32'(irq_m), 0, "R3 priority zero drops line");
    wr(22'h00C, 5); settle();
    chk(32'(irq_m), 1, "R3 priority restore");
    rd(A_CLM0, 3, "R5 claim after restore");
    wr(A_CLM0, 3);

    wr(A_EN1, 32'h40); wr(A_THR1, 0); pulse(6); settle();
    chk(32'(irq_s), 1, "R8 odd context supervisor line");
    chk(32'(irq_m), 0, "R8 even context not enabled for 6");
    rd(A_CLM1, 6, "R5 claim on odd context");
    wr(A_CLM1, 6);

    wr(22'h100, 32'hFFFF);
    rd(22'h100, 0, "R9 gap reads zero");
    wr(A_PEND, 32'hFF);
    rd(A_PEND, 0, "R9 pending read-only");
    rd(22'h200008, 0, "R9 gap after claim");
    rd(A_EN0, 32'h28, "R9 enable readback");
    wr(A_THR1, 3);
    rd(A_THR1, 3, "R9 threshold readback");

    settle();
    chk(32'(exp_q.size()), 0, "R11 all reads answered");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule